// File: doc/BRIEF.md
# Half-Duplex Serial Port with Line Polarity Control

This block moves characters over a two-wire asynchronous serial link in which only one direction is in use at any moment. A host writes a byte through a simple register-style data port and the block serialises it on the transmit pin. When no transmission is running, the block watches the receive pin, reassembles incoming characters and raises a ready flag. Status outputs show that the line is busy, that a character is waiting, and whether a framing or parity error was seen.

The character format is set by static inputs: 5 to 8 data bits sent least significant bit first, no parity, odd parity or even parity, and one or two stop bits. A polarity input inverts both pins, so the idle line is low instead of high. Bit timing comes from a built-in divider. It produces a 16x oversample tick from a 16-bit reload value and is restarted at the start of every frame. Because only one direction runs at a time, both directions share this divider.

Top module: `hdx_uart`

## Requirements
- R1: With divisor value D on `divisor_i`, the oversample tick period is D+1 clocks. Every bit on the line therefore lasts exactly 16*(D+1) clocks, counted from the clock edge that starts the frame.
- R2: A write accepted at a clock edge drives the start bit (line level 0) from that edge. It is followed by the data bits, least significant first, then the optional parity bit, then the stop bits (line level 1). `busy_o` is high from that edge until the edge that ends the last stop bit. The data length is 5 + `len_code_i` (codes 0..3), and `two_stop_i`=1 selects two stop bits.
- R3: `par_mode_i` code 0 means no parity, 1 odd, 2 even, and 3 behaves as no parity. With odd parity the data bits and the parity bit hold an odd number of ones. With even parity they hold an even number.
- R4: With `invert_i`=1, `txd_o` is the complement of the line level and `rxd_i` is complemented before use. The idle `txd_o` is 1 with `invert_i`=0 and 0 with `invert_i`=1.
- R5: A write while `busy_o` is high, whether from transmission or reception, is ignored and leaves the line and the model of the frame in progress unchanged.
- R6: The receive pin passes through two synchroniser flops. While idle, a line level of 0 starts reception at the next edge. `busy_o` is then high until the middle of the first stop bit. At that point the data (zero-extended) appears on `rx_data_o` and `rx_ready_o` goes to 1. Each bit is sampled on the 8th tick of that bit.
- R7: A start bit whose mid-bit sample is not 0 returns the receiver to idle, with no flag change.
- R8: A stop sample of 0 sets `frame_err_o`, and a parity mismatch sets `par_err_o`. Both flags stay set until a cycle with `rd_stat_i`=1. If a flag is set and `rd_stat_i` is high in the same cycle, the set wins.
- R9: `rx_ready_o` is cleared by a cycle with `rd_data_i`=1. If a character completes in that same cycle, the flag stays set.
- R10: While a transmission is in progress, activity on `rxd_i` is ignored and no character is received.
- R11: If a write is accepted in the same cycle that a start level would begin reception, the write wins and no reception starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| divisor_i | input | 16 | Divider reload value D, tick every D+1 clocks |
| len_code_i | input | 2 | Data length code, length = 5 + code |
| par_mode_i | input | 2 | 0 none, 1 odd, 2 even, 3 none |
| two_stop_i | input | 1 | 1 selects two stop bits |
| invert_i | input | 1 | 1 inverts both line pins |
| wr_en_i | input | 1 | Write strobe for transmit data |
| wr_data_i | input | 8 | Transmit character |
| rd_data_i | input | 1 | Receive data read strobe, clears ready |
| rd_stat_i | input | 1 | Status read strobe, clears error flags |
| rxd_i | input | 1 | Receive pin |
| txd_o | output | 1 | Transmit pin |
| busy_o | output | 1 | Line in use in either direction |
| rx_ready_o | output | 1 | Received character waiting |
| rx_data_o | output | 8 | Last received character |
| frame_err_o | output | 1 | Sticky framing error |
| par_err_o | output | 1 | Sticky parity error |

## Verification
The same cycle can carry the completion of a received character and a host status or data read. The bench computes the exact completion edge from the divisor and the synchroniser delay. It drives both read strobes into that cycle, and cuts the bad stop level short so that the line is idle again right after the sample. The flags must still read set afterwards. A second collision pairs a write with the edge at which a falling receive line would begin reception. The transmit waveform must then follow the reference model on every clock and no character may appear.

// File: rtl/hdx_uart_pkg.sv
package hdx_uart_pkg;
  localparam int DATA_MAX  = 8;
  localparam int DATA_MIN  = DATA_MAX - 3;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  function automatic logic par_on(input logic [1:0] mode);
    return (mode == 2'd1) || (mode == 2'd2);
  endfunction

  // mode 1: odd total ones, otherwise even
  function automatic logic par_bit(input logic [DATA_MAX-1:0] d, input logic [1:0] mode);
    return (mode == 2'd1) ? ~(^d) : (^d);
  endfunction
endpackage

// File: rtl/hdx_uart_baud.sv
module hdx_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i || cnt_q == '0)  cnt_q <= divisor_i;
    else                                cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  assert_tick_reload_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i) |=> (cnt_q == $past(divisor_i)));
endmodule

// File: rtl/hdx_uart_tx.sv
module hdx_uart_tx
  import hdx_uart_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic [DATA_MAX-1:0] data_i,
  input  logic [1:0]          len_code_i,
  input  logic [1:0]          par_mode_i,
  input  logic                two_stop_i,
  output logic                active_o,
  output logic                line_o
);
  localparam int OS_W  = $clog2(OS_RATE);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);

  logic [FRAME_MAX-1:0] sh_q, frame_d;
  logic [CNT_W-1:0]     left_q, n_d;
  logic [OS_W-1:0]      os_q;
  logic                 act_q;
  logic [DATA_MAX-1:0]  dm;

  always_comb begin
    int nb;
    nb = DATA_MIN + int'(len_code_i);
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      dm[i] = (i < nb) ? data_i[i] : 1'b0;
      if (i < nb) frame_d[1+i] = data_i[i];
    end
    if (par_on(par_mode_i)) frame_d[CNT_W'(1 + nb)] = par_bit(dm, par_mode_i);
    n_d = CNT_W'(1 + nb + (par_on(par_mode_i) ? 1 : 0) + (two_stop_i ? 2 : 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      os_q   <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      sh_q   <= frame_d;
      left_q <= n_d;
      os_q   <= '0;
    end else if (act_q && tick_i) begin
      os_q <= (os_q == OS_LAST) ? '0 : os_q + 1'b1;
      if (os_q == OS_LAST) begin
        if (left_q == CNT_W'(1)) act_q <= 1'b0;
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign active_o = act_q;
  assign line_o   = act_q ? sh_q[0] : 1'b1;

  assert_frame_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (left_q != '0 && left_q <= CNT_W'(FRAME_MAX)));
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> !line_o);
endmodule

// File: rtl/hdx_uart_rx.sv
module hdx_uart_rx
  import hdx_uart_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rxd_i,
  input  logic                invert_i,
  input  logic                tx_active_i,
  input  logic                block_i,
  input  logic [1:0]          len_code_i,
  input  logic [1:0]          par_mode_i,
  input  logic                rd_data_i,
  input  logic                rd_stat_i,
  output logic                start_o,
  output logic                active_o,
  output logic [DATA_MAX-1:0] data_o,
  output logic                ready_o,
  output logic                frame_err_o,
  output logic                par_err_o
);
  localparam int OS_W  = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);
  localparam logic [OS_W-1:0] OS_MID  = OS_W'(OS_RATE / 2 - 1);

  rx_state_e           state_q;
  logic                sync1_q, line_q;
  logic [OS_W-1:0]     os_q;
  logic [IDX_W-1:0]    idx_q, last_idx;
  logic [DATA_MAX-1:0] sh_q;
  logic                perr_q, mid, done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      line_q  <= 1'b1;
    end else begin
      sync1_q <= rxd_i ^ invert_i;
      line_q  <= sync1_q;
    end
  end

  assign last_idx = IDX_W'(DATA_MIN - 1) + IDX_W'(len_code_i);
  assign mid      = tick_i && (os_q == OS_MID);
  assign done     = (state_q == RX_STOP) && mid;
  assign start_o  = (state_q == RX_IDLE) && !line_q && !tx_active_i && !block_i;
  assign active_o = (state_q != RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      perr_q  <= 1'b0;
    end else if (state_q == RX_IDLE) begin
      if (start_o) begin
        state_q <= RX_START;
        os_q    <= '0;
        idx_q   <= '0;
        sh_q    <= '0;
        perr_q  <= 1'b0;
      end
    end else if (tick_i) begin
      os_q <= (os_q == OS_LAST) ? '0 : os_q + 1'b1;
      if (os_q == OS_MID) begin
        case (state_q)
          RX_START: state_q <= line_q ? RX_IDLE : RX_DATA;
          RX_DATA: begin
            sh_q[idx_q] <= line_q;
            idx_q       <= idx_q + 1'b1;
            if (idx_q == last_idx) state_q <= par_on(par_mode_i) ? RX_PAR : RX_STOP;
          end
          RX_PAR: begin
            perr_q  <= (line_q != par_bit(sh_q, par_mode_i));
            state_q <= RX_STOP;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // set has priority over the read-side clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      ready_o     <= 1'b0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
    end else begin
      if (done) data_o <= sh_q;
      if (done) ready_o <= 1'b1;
      else if (rd_data_i) ready_o <= 1'b0;
      if (done && !line_q) frame_err_o <= 1'b1;
      else if (rd_stat_i) frame_err_o <= 1'b0;
      if (done && perr_q) par_err_o <= 1'b1;
      else if (rd_stat_i) par_err_o <= 1'b0;
    end
  end

  assert_rx_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |-> (state_q == RX_IDLE));
  assert_ready_from_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(state_q) == RX_STOP));
  assert_false_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && mid && line_q) |=> (state_q == RX_IDLE));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !rd_stat_i) |=> frame_err_o);
endmodule

// File: rtl/hdx_uart.sv
module hdx_uart
  import hdx_uart_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int OS_RATE = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    divisor_i,
  input  logic [1:0]          len_code_i,
  input  logic [1:0]          par_mode_i,
  input  logic                two_stop_i,
  input  logic                invert_i,
  input  logic                wr_en_i,
  input  logic [DATA_MAX-1:0] wr_data_i,
  input  logic                rd_data_i,
  input  logic                rd_stat_i,
  input  logic                rxd_i,
  output logic                txd_o,
  output logic                busy_o,
  output logic                rx_ready_o,
  output logic [DATA_MAX-1:0] rx_data_o,
  output logic                frame_err_o,
  output logic                par_err_o
);
  logic tick, tx_start, rx_start, tx_active, rx_active, tx_line;

  assign busy_o   = tx_active | rx_active;
  assign tx_start = wr_en_i & ~busy_o;

  hdx_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni,
    .restart_i (tx_start | rx_start),
    .divisor_i,
    .tick_o    (tick)
  );

  hdx_uart_tx #(.OS_RATE(OS_RATE)) u_tx (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .start_i    (tx_start),
    .data_i     (wr_data_i),
    .len_code_i,
    .par_mode_i,
    .two_stop_i,
    .active_o   (tx_active),
    .line_o     (tx_line)
  );

  hdx_uart_rx #(.OS_RATE(OS_RATE)) u_rx (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .rxd_i,
    .invert_i,
    .tx_active_i (tx_active),
    .block_i     (tx_start),
    .len_code_i,
    .par_mode_i,
    .rd_data_i,
    .rd_stat_i,
    .start_o     (rx_start),
    .active_o    (rx_active),
    .data_o      (rx_data_o),
    .ready_o     (rx_ready_o),
    .frame_err_o,
    .par_err_o
  );

  assign txd_o = tx_line ^ invert_i;

  assert_one_direction_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_active && rx_active));
endmodule

// File: tb/hdx_uart_tb.sv
`timescale 1ns/1ps
module hdx_uart_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] divisor_i = 16'd2;
  logic [1:0]  len_code_i = 2'd3;
  logic [1:0]  par_mode_i = 2'd0;
  logic        two_stop_i = 1'b0;
  logic        invert_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic        rd_data_i = 1'b0;
  logic        rd_stat_i = 1'b0;
  logic        rxd_i = 1'b1;
  logic        txd_o, busy_o, rx_ready_o, frame_err_o, par_err_o;
  logic [7:0]  rx_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // reference model of the current frame window
  int          m_from = -1, m_to = -1, m_bl = 1;
  bit          m_tx = 1'b0;
  logic [11:0] m_frame = '1;

  hdx_uart u_dut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk_i);
    #2;
    if (cmp_on) begin
      bit eb;
      logic el;
      eb = (cyc >= m_from) && (cyc < m_to);
      el = (m_tx && eb) ? m_frame[(cyc - m_from) / m_bl] : 1'b1;
      chk("R5 busy", int'(busy_o), int'(eb));
      chk("R1/R2 txd", int'(txd_o), int'(el ^ invert_i));
    end
  end

  task automatic mk(input logic [7:0] d, output logic [11:0] f, output int n, output int js);
    int len, ones;
    len = 5 + int'(len_code_i);
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < len; i++) begin
      f[1+i] = d[i];
      ones += int'(d[i]);
    end
    n = 1 + len;
    if (par_mode_i == 2'd1 || par_mode_i == 2'd2) begin
      f[n] = (par_mode_i == 2'd1) ? ((ones % 2) == 0) : ((ones % 2) == 1);
      n++;
    end
    js = n;
    n += two_stop_i ? 2 : 1;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk_i);
  endtask

  task automatic tx_start(input logic [7:0] d);
    int n, js;
    logic [11:0] f;
    mk(d, f, n, js);
    m_tx = 1'b1;
    m_frame = f;
    m_bl = 16 * (int'(divisor_i) + 1);
    m_from = cyc + 1;
    m_to = m_from + n * m_bl;
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rx_frame(input logic [11:0] bits, input int n, input int js,
                          input int wr_at, input bit coinc, input bit cut);
    int c_s, p;
    p = int'(divisor_i) + 1;
    c_s = cyc + 1;
    m_tx = 1'b0;
    m_from = c_s + 2;
    m_to = c_s + 2 + (16 * js + 8) * p;
    fork
      begin
        for (int j = 0; j < n; j++) begin
          rxd_i = bits[j] ^ invert_i;
          repeat (16 * p) @(negedge clk_i);
        end
        rxd_i = ~invert_i;
      end
      begin
        if (wr_at >= 0) begin
          repeat (wr_at) @(negedge clk_i);
          pulse_wr(8'hFF);
        end
      end
      begin
        if (coinc) begin
          wait_cyc(m_to - 2);
          if (cut) rxd_i = ~invert_i;
          @(negedge clk_i);
          rd_stat_i = 1'b1;
          rd_data_i = 1'b1;
          @(negedge clk_i);
          rd_stat_i = 1'b0;
          rd_data_i = 1'b0;
        end
      end
    join
  endtask

  task automatic rd_pulse(input bit dat, input bit stat);
    rd_data_i = dat;
    rd_stat_i = stat;
    @(negedge clk_i);
    rd_data_i = 1'b0;
    rd_stat_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] f;
    int n, js, c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R4 reset idle txd", int'(txd_o), 1);
    chk("R2 reset busy", int'(busy_o), 0);
    chk("R6 reset ready", int'(rx_ready_o), 0);
    chk("R8 reset errors", int'(frame_err_o | par_err_o), 0);
    cmp_on = 1'b1;

    // R2/R5: 8 data, no parity, one stop, write mid-frame ignored
    tx_start(8'hA5);
    repeat (100) @(negedge clk_i);
    pulse_wr(8'hFF);
    wait_cyc(m_to + 4);

    // R1/R3: D=0, 5 bits even parity, two stops
    divisor_i = 16'd0; len_code_i = 2'd0; par_mode_i = 2'd2; two_stop_i = 1'b1;
    @(negedge clk_i);
    tx_start(8'h13);
    wait_cyc(m_to + 4);

    // R4/R3: inverted line, 7 bits odd parity
    divisor_i = 16'd1; len_code_i = 2'd2; par_mode_i = 2'd1; two_stop_i = 1'b0;
    invert_i = 1'b1; rxd_i = 1'b0;
    @(negedge clk_i);
    chk("R4 inverted idle txd", int'(txd_o), 0);
    tx_start(8'h55);
    wait_cyc(m_to + 4);
    chk("R4 inverted idle after frame", int'(txd_o), 0);
    invert_i = 1'b0; rxd_i = 1'b1;

    // R6/R5: receive 8N1 with a write attempted mid-frame
    divisor_i = 16'd2; len_code_i = 2'd3; par_mode_i = 2'd0; two_stop_i = 1'b0;
    repeat (4) @(negedge clk_i);
    mk(8'h3C, f, n, js);
    rx_frame(f, n, js, 90, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    chk("R6 ready", int'(rx_ready_o), 1);
    chk("R6 data", int'(rx_data_o), 8'h3C);
    chk("R8 no frame err", int'(frame_err_o), 0);
    chk("R8 no parity err", int'(par_err_o), 0);
    rd_pulse(1'b1, 1'b0);
    chk("R9 ready cleared by data read", int'(rx_ready_o), 0);

    // R8: odd parity with corrupted parity bit
    par_mode_i = 2'd1;
    repeat (4) @(negedge clk_i);
    mk(8'h3C, f, n, js);
    f[js-1] = ~f[js-1];
    rx_frame(f, n, js, -1, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    chk("R8 parity err set", int'(par_err_o), 1);
    chk("R8 frame err clear", int'(frame_err_o), 0);
    chk("R6 data with parity", int'(rx_data_o), 8'h3C);
    rd_pulse(1'b0, 1'b1);
    chk("R8 parity err cleared by status read", int'(par_err_o), 0);
    rd_pulse(1'b1, 1'b0);

    // R8/R9: bad stop, both reads in the completion cycle
    par_mode_i = 2'd0; len_code_i = 2'd1; two_stop_i = 1'b1;
    repeat (4) @(negedge clk_i);
    mk(8'h2A, f, n, js);
    f[js] = 1'b0;
    rx_frame(f, n, js, -1, 1'b1, 1'b1);
    repeat (4) @(negedge clk_i);
    chk("R8 frame err set wins over status read", int'(frame_err_o), 1);
    chk("R9 ready set wins over data read", int'(rx_ready_o), 1);
    chk("R6 data 6-bit", int'(rx_data_o), 8'h2A);
    rd_pulse(1'b1, 1'b1);
    chk("R8 frame err cleared", int'(frame_err_o), 0);
    chk("R9 ready cleared", int'(rx_ready_o), 0);

    // R4: inverted receive, 6 bits even parity
    invert_i = 1'b1; rxd_i = 1'b0; par_mode_i = 2'd2; two_stop_i = 1'b0;
    repeat (4) @(negedge clk_i);
    mk(8'h0B, f, n, js);
    rx_frame(f, n, js, -1, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    chk("R4 inverted rx data", int'(rx_data_o), 8'h0B);
    chk("R4 inverted rx ready", int'(rx_ready_o), 1);
    chk("R4 inverted rx no parity err", int'(par_err_o), 0);
    rd_pulse(1'b1, 1'b0);
    invert_i = 1'b0; rxd_i = 1'b1; par_mode_i = 2'd0; len_code_i = 2'd3;
    repeat (4) @(negedge clk_i);

    // R7: short low pulse rejected at mid start bit
    c0 = cyc + 1;
    m_tx = 1'b0;
    m_from = c0 + 2;
    m_to = c0 + 2 + 8 * (int'(divisor_i) + 1);
    rxd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rxd_i = 1'b1;
    wait_cyc(m_to + 20);
    chk("R7 no ready after glitch", int'(rx_ready_o), 0);
    chk("R7 no error after glitch", int'(frame_err_o | par_err_o), 0);

    // R10: receive line toggles during transmission
    tx_start(8'hC3);
    repeat (60) @(negedge clk_i);
    rxd_i = 1'b0; repeat (50) @(negedge clk_i);
    rxd_i = 1'b1; repeat (30) @(negedge clk_i);
    rxd_i = 1'b0; repeat (40) @(negedge clk_i);
    rxd_i = 1'b1;
    wait_cyc(m_to + 100);
    chk("R10 nothing received during tx", int'(rx_ready_o), 0);

    // R11: write in the same cycle reception would start
    rxd_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    tx_start(8'h5A);
    repeat (30) @(negedge clk_i);
    rxd_i = 1'b1;
    wait_cyc(m_to + 100);
    chk("R11 write wins, no reception", int'(rx_ready_o), 0);
    chk("R11 line free afterwards", int'(busy_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule